// File: doc/BRIEF.md
# Self-Timed Byte-Write Nonvolatile Memory Controller

This block is the clocked control core of a byte-wide nonvolatile memory. A host drives active-low chip-enable, output-enable and write-enable strobes with an address and a data byte, much like a static RAM. Reads return the stored byte at once. A write only has to present a short strobe pulse. The block captures the address and the byte, then finishes the erase and program sequence by itself under an internal timer. During that time the host bus is free for other work.

All pin inputs are resampled into the system clock domain before they are decoded. While a write is in progress the block pulls its ready/busy line low. That line is modelled as a pulldown-enable output, so several devices can share one wire. A read taken during that time acts as a poll: the top data bit comes back inverted from the byte being written.

Two supply-sense inputs, together with a power-up hold-off timer, keep spurious writes out of the array. The array is a register bank that comes out of reset fully erased.

Top module: `eep_byte_write_top`

## Requirements
- R1: The outputs follow the resampled pins. A read (ce_n=0, oe_n=0, we_n=1) sets data_oe=1 and drives the byte stored at addr on data_out. Every other strobe combination gives data_oe=0 and data_out=0.
- R2: A write is a pulse during which ce_n and we_n are both low and oe_n is high. Either strobe may be the one that opens and closes the pulse.
- R3: The address is taken when the pulse opens, which is the fall of the later strobe. The data byte is taken when the pulse closes, which is the rise of the earlier strobe. Changes to addr after the opening therefore do not move the write, and the last data seen before the closing is what gets stored.
- R4: An accepted write keeps the block busy for exactly WRITE_CYCLES clock cycles. The first half of that time is an erase phase and the rest is a program phase. The array byte changes only on the last busy cycle.
- R5: rb_pull_low is 1 on every busy cycle and 0 otherwise.
- R6: A read on any address while busy returns a poll byte. Bit 7 is the inverse of bit 7 of the byte being written, and bits 6:0 are the old stored bits 6:0 at the write address. Once busy ends, the new byte reads back in full.
- R7: No write takes place when oe_n is low while ce_n and we_n are both low.
- R8: No write takes place while vcc_ok is 0.
- R9: Writes are refused until POWERUP_CYCLES cycles after vcc_start is first seen high. The lock stays released even if vcc_start later drops.
- R10: A write pulse that opens while busy is ignored. The write in flight keeps its address and data.
- R11: Reset clears busy and data_oe, sets every array byte to 8'hFF and re-arms the power-up lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| vcc_ok | input | 1 | Supply above the write-inhibit threshold |
| vcc_start | input | 1 | Supply has reached its start-up level |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data toward the host |
| data_oe | output | 1 | Data output driver enable |
| rb_pull_low | output | 1 | 1 pulls the shared ready/busy line low |

## Verification
The bench builds the block with ADDR_W=4, WRITE_CYCLES=12 and POWERUP_CYCLES=20. The sixteen-byte array makes a full write-and-read sweep of every address affordable, alternating between write-enable and chip-enable control. The short write time means the length of each busy window can be counted to the cycle. It also leaves room to fit a poll read or a second write pulse inside that window. The short hold-off lets the lock be seen both before and after it releases within one run.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int DATA_W   = 8;
    localparam int POLL_BIT = DATA_W - 1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_PROG  = 2'd2
    } wr_phase_e;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic vcc_ok;
        logic vcc_start;
    } ctl_pins_t;

    localparam ctl_pins_t CTL_RESET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                        vcc_ok: 1'b0, vcc_start: 1'b0};

    function automatic bus_mode_e decode_bus(input ctl_pins_t p);
        if (!p.ce_n && !p.oe_n && p.we_n)
            return BUS_READ;
        else if (!p.ce_n && !p.we_n && p.oe_n)
            return BUS_WRITE;
        else
            return BUS_IDLE;
    endfunction

    function automatic logic [DATA_W-1:0] poll_byte(input logic [DATA_W-1:0] old_b,
                                                    input logic [DATA_W-1:0] new_b);
        return {~new_b[POLL_BIT], old_b[POLL_BIT-1:0]};
    endfunction

endpackage

// File: rtl/eep_input_sync.sv
module eep_input_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array
    import eep_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eep_write_ctrl.sv
module eep_write_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W         = 11,
    parameter int WRITE_CYCLES   = 150000,
    parameter int POWERUP_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_mode_e         mode,
    input  logic              vcc_ok,
    input  logic              vcc_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data,
    output logic              mem_we
);
    localparam int WC_W         = $clog2(WRITE_CYCLES);
    localparam int PU_W         = $clog2(POWERUP_CYCLES);
    localparam int ERASE_CYCLES = WRITE_CYCLES / 2;
    localparam logic [WC_W-1:0] WC_FIRST   = WC_W'(WRITE_CYCLES - 1);
    localparam logic [WC_W-1:0] ERASE_LAST = WC_W'(WRITE_CYCLES - ERASE_CYCLES);
    localparam logic [PU_W-1:0] PU_LAST    = PU_W'(POWERUP_CYCLES - 1);

    wr_phase_e       phase;
    logic [WC_W-1:0] cnt;
    logic [PU_W-1:0] pu_cnt;
    logic            pu_run, pu_done;
    logic            wr_prev, armed;
    logic            wr_now, pulse_open, pulse_close, commit;

    assign wr_now      = (mode == BUS_WRITE);
    assign pulse_open  = wr_now && !wr_prev;
    assign pulse_close = !wr_now && wr_prev;
    assign commit      = pulse_close && armed && vcc_ok;
    assign busy        = (phase != PH_IDLE);
    assign mem_we      = (phase == PH_PROG) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            pu_cnt    <= '0;
            pu_run    <= 1'b0;
            pu_done   <= 1'b0;
            wr_prev   <= 1'b0;
            armed     <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            wr_prev <= wr_now;

            if (vcc_start) pu_run <= 1'b1;
            if ((pu_run || vcc_start) && !pu_done) begin
                if (pu_cnt == PU_LAST) pu_done <= 1'b1;
                else                   pu_cnt  <= pu_cnt + 1'b1;
            end

            if (pulse_open) begin
                armed <= !busy && vcc_ok && pu_done;
                if (!busy) pend_addr <= addr;
            end else if (pulse_close) begin
                armed <= 1'b0;
            end

            if (commit) begin
                pend_data <= din;
                phase     <= PH_ERASE;
                cnt       <= WC_FIRST;
            end else if (phase != PH_IDLE) begin
                if (cnt == '0) begin
                    phase <= PH_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                    if (cnt == ERASE_LAST) phase <= PH_PROG;
                end
            end
        end
    end

    localparam int RL_W = $clog2(WRITE_CYCLES + 1) + 1;
    logic [RL_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_len == RL_W'(WRITE_CYCLES));
    // R4
    erase_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> phase == PH_ERASE);
    // R4
    store_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !busy);
    // R9
    powerup_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> pu_done);
    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(pend_addr) && $stable(pend_data));
endmodule

// File: rtl/eep_byte_write_top.sv
module eep_byte_write_top
    import eep_pkg::*;
#(
    parameter int ADDR_W         = 11,
    parameter int WRITE_CYCLES   = 150000,
    parameter int POWERUP_CYCLES = 500000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              vcc_ok,
    input  logic              vcc_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic              rb_pull_low
);
    localparam int CTL_W = $bits(ctl_pins_t);
    localparam int BUS_W = ADDR_W + DATA_W;

    ctl_pins_t         ctl_raw, ctl_s;
    logic [BUS_W-1:0]  bus_s;
    logic [ADDR_W-1:0] addr_s, pend_addr, rd_addr;
    logic [DATA_W-1:0] din_s, pend_data, rd_byte;
    logic              busy, mem_we;
    bus_mode_e         mode;

    assign ctl_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n,
                       vcc_ok: vcc_ok, vcc_start: vcc_start};

    eep_input_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RESET)) ctl_sync_i (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s));

    eep_input_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) bus_sync_i (
        .clk(clk), .rst(rst), .d({addr, data_in}), .q(bus_s));

    assign {addr_s, din_s} = bus_s;
    assign mode = decode_bus(ctl_s);

    eep_write_ctrl #(
        .ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES), .POWERUP_CYCLES(POWERUP_CYCLES)
    ) ctrl_i (
        .clk(clk), .rst(rst), .mode(mode), .vcc_ok(ctl_s.vcc_ok), .vcc_start(ctl_s.vcc_start),
        .addr(addr_s), .din(din_s), .busy(busy), .pend_addr(pend_addr),
        .pend_data(pend_data), .mem_we(mem_we));

    assign rd_addr = busy ? pend_addr : addr_s;

    eep_cell_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rst(rst), .wr_en(mem_we), .wr_addr(pend_addr), .wr_data(pend_data),
        .rd_addr(rd_addr), .rd_data(rd_byte));

    assign data_oe     = (mode == BUS_READ);
    assign rb_pull_low = busy;

    always_comb begin
        if (!data_oe)  data_out = '0;
        else if (busy) data_out = poll_byte(rd_byte, pend_data);
        else           data_out = rd_byte;
    end

    // R6
    poll_bit_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe && busy |-> data_out[POLL_BIT] != pend_data[POLL_BIT]);
endmodule

// File: tb/eep_byte_write_tb.sv
module eep_byte_write_top_tb_top;
    localparam int AW = 4;
    localparam int WC = 12;
    localparam int PU = 20;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic          vcc_ok = 1'b1, vcc_start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data_in = '0;
    logic [7:0]    data_out;
    logic          data_oe, rb_pull_low;

    int   errs = 0;
    int   checks = 0;
    bit   reported = 1'b0;
    logic [7:0] expv [NB];

    eep_byte_write_top #(.ADDR_W(AW), .WRITE_CYCLES(WC), .POWERUP_CYCLES(PU)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .vcc_ok(vcc_ok), .vcc_start(vcc_start), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .rb_pull_low(rb_pull_low));

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
        end
        $finish;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic read_byte(input logic [AW-1:0] a, output logic [7:0] v, output logic oe);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        step(3);
        @(negedge clk);
        v = data_out; oe = data_oe;
        step(1);
        ce_n = 1'b1; oe_n = 1'b1;
        step(3);
    endtask

    task automatic pulse_we(input logic [AW-1:0] a, input logic [7:0] d);
        ce_n = 1'b0; oe_n = 1'b1; addr = a; data_in = d;
        step(1); we_n = 1'b0;
        step(3); we_n = 1'b1;
        step(1); ce_n = 1'b1;
    endtask

    task automatic pulse_ce(input logic [AW-1:0] a, input logic [7:0] d,
                            input logic [AW-1:0] a2, input logic [7:0] d2);
        we_n = 1'b0; oe_n = 1'b1; ce_n = 1'b1; addr = a; data_in = d;
        step(1); ce_n = 1'b0;
        step(3); addr = a2; data_in = d2;
        step(3); ce_n = 1'b1;
        step(1); we_n = 1'b1;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        repeat (WC + 12) begin
            @(negedge clk);
            if (rb_pull_low) n++;
        end
        #2;
    endtask

    task automatic verify_all(input string req);
        logic [7:0] v; logic oe;
        for (int a = 0; a < NB; a++) begin
            read_byte(AW'(a), v, oe);
            check(req, {23'd0, oe, v}, {23'd0, 1'b1, expv[a]});
        end
    endtask

    initial begin
        #(200000 * 20);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        int n;
        logic [7:0] v, d;
        logic oe;

        for (int a = 0; a < NB; a++) expv[a] = 8'hFF;
        step(3);
        @(negedge clk);
        check("R11 rb in reset", {31'd0, rb_pull_low}, 32'd0);
        check("R11 oe in reset", {31'd0, data_oe}, 32'd0);
        rst = 1'b0;
        step(2);
        verify_all("R11 erased array");

        // R9: lock before vcc_start, and just after it rises
        pulse_we(4'd1, 8'h5A); count_busy(n);
        check("R9 no write before start level", n, 0);
        vcc_start = 1'b1;
        pulse_we(4'd1, 8'h5A); count_busy(n);
        check("R9 no write during hold-off", n, 0);
        read_byte(4'd1, v, oe);
        check("R9 byte untouched", v, 8'hFF);
        vcc_start = 1'b0;
        step(30);
        pulse_we(4'd1, 8'h5A); count_busy(n);
        check("R9 write after hold-off", n, WC);
        expv[1] = 8'h5A;

        // R2 R4 R5 sweep
        for (int a = 0; a < NB; a++) begin
            d = 8'(a * 29 + 7) ^ 8'(a << 5);
            if (a[0]) pulse_ce(AW'(a), d, AW'(a), d);
            else      pulse_we(AW'(a), d);
            count_busy(n);
            check("R4 R5 busy length", n, WC);
            expv[a] = d;
        end
        verify_all("R1 R2 sweep readback");

        // R6 polling, at the write address and at another address
        for (int k = 0; k < 2; k++) begin
            int wa, ra;
            wa = (k == 0) ? 3 : 12;
            ra = (k == 0) ? 3 : 5;
            d = ~expv[wa];
            pulse_we(AW'(wa), d);
            addr = AW'(ra); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
            step(2);
            @(negedge clk);
            check("R5 busy while polling", {31'd0, rb_pull_low}, 32'd1);
            check("R6 poll byte", {23'd0, data_oe, data_out},
                  {23'd0, 1'b1, ~d[7], expv[wa][6:0]});
            addr = AW'(wa);
            step(WC + 4);
            @(negedge clk);
            check("R5 released", {31'd0, rb_pull_low}, 32'd0);
            check("R6 true data after busy", data_out, d);
            step(1);
            ce_n = 1'b1; oe_n = 1'b1;
            step(3);
            expv[wa] = d;
        end

        // R3 capture points, chip-enable and write-enable controlled
        pulse_ce(4'd6, 8'h11, 4'd9, 8'hC3); count_busy(n);
        check("R3 ce-controlled busy", n, WC);
        expv[6] = 8'hC3;
        ce_n = 1'b0; oe_n = 1'b1; addr = 4'd10; data_in = 8'h01;
        step(1); we_n = 1'b0;
        step(3); addr = 4'd4; data_in = 8'h3C;
        step(3); we_n = 1'b1;
        step(1); ce_n = 1'b1;
        count_busy(n);
        check("R3 we-controlled busy", n, WC);
        expv[10] = 8'h3C;
        verify_all("R3 capture readback");

        // R7 output enable low during overlap
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 4'd2; data_in = 8'h00;
        step(3);
        @(negedge clk);
        check("R1 no drive while we low", {31'd0, data_oe}, 32'd0);
        step(2);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        count_busy(n);
        check("R7 oe low blocks write", n, 0);

        // R8 supply below threshold
        vcc_ok = 1'b0;
        step(3);
        pulse_we(4'd7, 8'h77); count_busy(n);
        check("R8 low supply blocks write", n, 0);
        vcc_ok = 1'b1;
        step(3);
        verify_all("R7 R8 array unchanged");

        // R10 second pulse while busy
        pulse_we(4'd8, 8'hA5);
        pulse_we(4'd11, 8'h5A);
        step(WC + 6);
        @(negedge clk);
        check("R10 busy over", {31'd0, rb_pull_low}, 32'd0);
        step(1);
        expv[8] = 8'hA5;
        verify_all("R10 first write only");

        // R11 reset re-arms lock and erases
        rst = 1'b1; step(2); rst = 1'b0; step(2);
        pulse_we(4'd0, 8'h42); count_busy(n);
        check("R11 lock re-armed", n, 0);
        read_byte(4'd0, v, oe);
        check("R11 erased after reset", v, 8'hFF);

        report();
    end
endmodule